// File: doc/BRIEF.md
# Full-Period Galois Sequence Generator

This block produces a pseudo-random sequence from a shift register with feedback that fans out from the top bit. The feedback is XORed into the tapped stages as they shift. The width is a parameter from 2 to 32. The tap mask, and so the feedback polynomial, is chosen per width from a built-in table of maximal-length polynomials.

On top of the plain Galois structure, the feedback is also XORed with a NOR of every bit below the top one. This splices the all-zero word into the cycle. The register therefore walks through every one of its 2^n values before repeating, and all zeros is an ordinary state rather than a trap.

The block has only a clock and an active-high synchronous reset. It shows its whole register on one output and advances once on every clock edge. A width outside 2..32 stops elaboration.

Top module: `lfsr_fullcycle_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes all zeros at that edge.
- R2: From the all-zero state, the next state is the tap mask shifted up by one, with bit 0 set: bits [n-1:1] take tap bits [n-2:0] and bit 0 is 1.
- R3: The state with only bit n-1 set is followed by the all-zero state.
- R4: When bits [n-2:0] are not all zero, the next bit 0 equals the old bit n-1. Each higher bit N takes old bit N-1, inverted when old bit n-1 is 1 and tap bit N-1 is 1.
- R5: When bit n-1 is 0 and bits [n-2:0] are not all zero, the next state is the old state shifted left by one with a 0 entering bit 0.
- R6: Starting from all zeros, the state first returns to all zeros after exactly 2^n clock edges.
- R7: Tap bit k stands for the polynomial term x^(k+1), and bit n-1 is always set. Widths 2, 3, 8 and 32 use the masks 0b11, 0b101, 0x8E and 0x80000062. The other widths use two-tap or four-tap maximal-length polynomials.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset to all zeros |
| state | output | WIDTH | Current register contents |

## Verification
Every result of this block appears one rising edge after its cause. That applies both to a reset sampled at an edge and to each single step of the sequence.

The bench changes `rst` on the falling edge. It then reads `state` on the next falling edge, half a period after the edge that produced the value. Each per-step expectation is therefore tied to exactly one edge.

The full-period check starts from the reset state. It counts falling-edge samples until zero is seen again, so the count equals the number of rising edges taken.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    localparam int MIN_WIDTH = 2;
    localparam int MAX_WIDTH = 32;

    // one polynomial term x^e mapped to mask bit e-1
    function automatic logic [MAX_WIDTH-1:0] term(input int e);
        logic [MAX_WIDTH-1:0] m;
        m = '0;
        if (e >= 1 && e <= MAX_WIDTH)
            m[e-1] = 1'b1;
        return m;
    endfunction

    function automatic bit width_ok(input int w);
        return (w >= MIN_WIDTH) && (w <= MAX_WIDTH);
    endfunction

    // maximal-length polynomial per width; constant term is implied
    function automatic logic [MAX_WIDTH-1:0] tap_mask(input int w);
        logic [MAX_WIDTH-1:0] m;
        case (w)
            2:  m = term(1);
            3:  m = term(1);
            4:  m = term(1);
            5:  m = term(2);
            6:  m = term(1);
            7:  m = term(1);
            8:  m = term(4)  | term(3) | term(2);
            9:  m = term(4);
            10: m = term(3);
            11: m = term(2);
            12: m = term(6)  | term(4) | term(1);
            13: m = term(4)  | term(3) | term(1);
            14: m = term(5)  | term(3) | term(1);
            15: m = term(1);
            16: m = term(5)  | term(3) | term(2);
            17: m = term(3);
            18: m = term(7);
            19: m = term(5)  | term(2) | term(1);
            20: m = term(3);
            21: m = term(2);
            22: m = term(1);
            23: m = term(5);
            24: m = term(4)  | term(3) | term(1);
            25: m = term(3);
            26: m = term(6)  | term(2) | term(1);
            27: m = term(5)  | term(2) | term(1);
            28: m = term(3);
            29: m = term(2);
            30: m = term(6)  | term(4) | term(1);
            31: m = term(3);
            32: m = term(7)  | term(6) | term(2);
            default: m = '0;
        endcase
        return m | term(w);
    endfunction

endpackage

// File: rtl/lfsr_zero_splice.sv
module lfsr_zero_splice #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    output logic             feedback
);
    logic low_clear;

    // low bits all zero: either the zero word or the top-only word
    assign low_clear = ~|cur[WIDTH-2:0];
    assign feedback  = cur[WIDTH-1] ^ low_clear;

endmodule

// File: rtl/lfsr_galois_step.sv
module lfsr_galois_step #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = '1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             feedback,
    output logic [WIDTH-1:0] nxt
);
    assign nxt[0] = feedback;

    // at most one XOR between neighbouring stages
    for (genvar b = 1; b < WIDTH; b++) begin : g_stage
        if (TAPS[b-1]) begin : g_tap
            assign nxt[b] = cur[b-1] ^ feedback;
        end else begin : g_pass
            assign nxt[b] = cur[b-1];
        end
    end

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/lfsr_fullcycle_gen.sv
module lfsr_fullcycle_gen #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] state
);
    localparam logic [lfsr_pkg::MAX_WIDTH-1:0] TAP_FULL = lfsr_pkg::tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS      = TAP_FULL[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ZERO_NEXT = {TAPS[WIDTH-2:0], 1'b1};
    localparam logic [WIDTH-1:0] TOP_ONLY  = {1'b1, {(WIDTH-1){1'b0}}};

    if (!lfsr_pkg::width_ok(WIDTH)) begin : g_bad_width
        $error("lfsr_fullcycle_gen: WIDTH must lie in 2..32");
    end

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             fb;

    lfsr_zero_splice #(.WIDTH(WIDTH)) u_splice (
        .cur      (state_q),
        .feedback (fb)
    );

    lfsr_galois_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
        .cur      (state_q),
        .feedback (fb),
        .nxt      (state_d)
    );

    lfsr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (state_d),
        .q   (state_q)
    );

    assign state = state_q;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> state_q == '0);

    a_r2_zero_successor: assert property (@(posedge clk) disable iff (rst)
        (state_q == '0) |=> state_q == ZERO_NEXT);

    a_r3_top_only_to_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == TOP_ONLY) |=> state_q == '0);

    a_r4_bit0_takes_top: assert property (@(posedge clk) disable iff (rst)
        (|state_q[WIDTH-2:0]) |=> state_q[0] == $past(state_q[WIDTH-1]));

    a_r5_plain_shift: assert property (@(posedge clk) disable iff (rst)
        (!state_q[WIDTH-1] && |state_q[WIDTH-2:0])
        |=> state_q == {$past(state_q[WIDTH-2:0]), 1'b0});

endmodule

// File: tb/test_lfsr_fullcycle_gen.sv
module test_lfsr_fullcycle_gen;

    localparam int NW = 17;
    localparam int WIDTHS [NW] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12,
                                   13, 14, 15, 16, 24, 32};
    localparam int I_W2  = 0;
    localparam int I_W3  = 1;
    localparam int I_W4  = 2;
    localparam int I_W8  = 6;
    localparam int I_W32 = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] obs [NW];

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < NW; g++) begin : g_dut
        logic [WIDTHS[g]-1:0] st;
        lfsr_fullcycle_gen #(.WIDTH(WIDTHS[g])) i_lfsr_fullcycle_gen (
            .clk   (clk),
            .rst   (rst),
            .state (st)
        );
        assign obs[g] = 32'(st);
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        step();
        for (int i = 0; i < NW; i++)
            chk(obs[i] == 32'h0, "R1", obs[i], 32'h0);
    endtask

    // first step after reset: tap mask shifted up with bit 0 set
    task automatic t_zero_successor;
        rst = 1'b0;
        step();
        chk(obs[I_W2]  == 32'h3,  "R2 R7 width 2",  obs[I_W2],  32'h3);
        chk(obs[I_W3]  == 32'h3,  "R2 R7 width 3",  obs[I_W3],  32'h3);
        chk(obs[I_W4]  == 32'h3,  "R2 width 4",     obs[I_W4],  32'h3);
        chk(obs[I_W8]  == 32'h1D, "R2 R7 width 8",  obs[I_W8],  32'h1D);
        chk(obs[I_W32] == 32'hC5, "R2 R7 width 32", obs[I_W32], 32'hC5);
    endtask

    // width 2: 11 -> 01 -> 10 -> 00 ; width 4: 0011 -> 0110 -> 1100 -> 1011
    task automatic t_short_walk;
        step();
        chk(obs[I_W2] == 32'h1, "R4 width 2",      obs[I_W2], 32'h1);
        chk(obs[I_W4] == 32'h6, "R5 width 4",      obs[I_W4], 32'h6);
        step();
        chk(obs[I_W2] == 32'h2, "R5 width 2",      obs[I_W2], 32'h2);
        chk(obs[I_W4] == 32'hC, "R5 width 4",      obs[I_W4], 32'hC);
        step();
        chk(obs[I_W2] == 32'h0, "R3 width 2",      obs[I_W2], 32'h0);
        chk(obs[I_W4] == 32'hB, "R4 width 4",      obs[I_W4], 32'hB);
    endtask

    task automatic t_midrun_reset;
        repeat (37) step();
        chk(obs[I_W32] != 32'h0, "R1 pre-reset running", obs[I_W32], 32'h0);
        rst = 1'b1;
        step();
        for (int i = 0; i < NW; i++)
            chk(obs[i] == 32'h0, "R1 mid-run", obs[i], 32'h0);
    endtask

    task automatic t_full_period;
        int first [NW];
        for (int i = 0; i < NW; i++) first[i] = 0;
        rst = 1'b0;
        for (int c = 1; c <= 65536; c++) begin
            step();
            for (int i = 0; i < NW; i++)
                if (first[i] == 0 && obs[i] == 32'h0) first[i] = c;
        end
        for (int i = 0; i < NW; i++) begin
            if (WIDTHS[i] <= 16)
                chk(first[i] == (1 << WIDTHS[i]), "R6 period",
                    32'(first[i]), 32'(1 << WIDTHS[i]));
            else
                chk(first[i] == 0, "R6 no early return",
                    32'(first[i]), 32'h0);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_zero_successor();
        t_short_walk();
        t_midrun_reset();
        t_full_period();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule